// File: doc/BRIEF.md
# Exception Priority Vector Generator

This block chooses which exception a small 16-bit processor core services next. It watches every exception source in each clock cycle. These sources are the reset pin, a watchdog overflow, the non-maskable interrupt, a trap request with its 2-bit code, an address-break request and a bank of maskable interrupt lines. It picks the single winner and reports it as a one-cycle pulse, together with a vector number and the byte address of that vector's 2-byte table slot.

The core tells the block when an instruction, or the current exception sequence, has just completed. It does this with a boundary strobe. Interrupt-type sources are accepted only on that strobe. Trap requests and reset-class events are accepted in any cycle. The core's interrupt mask bit blocks the maskable interrupt lines only. The non-maskable interrupt and the address break ignore it.

The vector number and the vector address are registered. They keep their values until the next exception is accepted, so the core can read them at any point during its entry sequence.

Top module: `exc_vec_arbiter`

## Requirements
- R1: While `res_n` is low, `exc_taken` is 0 and `vec_num` and `vec_addr` are 0, whatever the request inputs do.
- R2: On the first rising clock edge after `res_n` goes high, `exc_taken` pulses with `vec_num` 0 and `vec_addr` 0x0000. This pulse happens once per release.
- R3: If `wdt_ovf` is high at a clock edge, the next cycle shows `exc_taken` with vector 0, address 0x0000. This ignores the boundary strobe, the mask and every other request.
- R4: A non-maskable request on a boundary gives vector 7, address 0x000E, even when `irq_mask` is 1.
- R5: A trap request with code n (0 to 3) gives vector 8+n, at addresses 0x0010, 0x0012, 0x0014 and 0x0016. It is accepted even when `insn_boundary` is 0.
- R6: Maskable line k gives vector 12+k and address 2*(12+k). It is accepted on a boundary with `irq_mask` 0. When several lines are active, the lowest-numbered one wins.
- R7: While `irq_mask` is 1, maskable lines produce no pulse, and `vec_num` and `vec_addr` keep their values.
- R8: An address-break request on a boundary gives vector 20 (address 0x0028). This vector comes right after the last maskable line. It is accepted even when `irq_mask` is 1.
- R9: When several eligible requests meet in one cycle, the one with the lowest vector number wins.
- R10: Without the boundary strobe, non-maskable, address-break and maskable requests produce no pulse.
- R11: `exc_taken` lasts one cycle per acceptance. Between acceptances, `vec_num` and `vec_addr` do not change.
- R12: The vector number is never in the reserved range 1 to 6, and `vec_addr` always equals `vec_num` times 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow, treated as a reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| trap_req | input | 1 | Trap instruction request |
| trap_code | input | 2 | Trap number 0 to 3 |
| brk_req | input | 1 | Address-break request |
| irq_req | input | NUM_IRQ | Maskable interrupt lines, bit 0 has the highest priority |
| irq_mask | input | 1 | Interrupt mask bit, 1 blocks the maskable lines |
| insn_boundary | input | 1 | Instruction or exception sequence has completed |
| exc_taken | output | 1 | One-cycle pulse when an exception is accepted |
| vec_num | output | VEC_W | Vector number of the accepted exception |
| vec_addr | output | ADDR_W | Byte address of the vector table entry |

## Verification
A trap is accepted in any cycle, and interrupts are accepted on the boundary strobe. These two functions can therefore meet in one cycle. The bench provokes this by raising a trap together with a maskable line, and in another step together with the non-maskable request, with the strobe high. The scoreboard expects only the lower vector number to appear. A separate step raises the non-maskable request with the strobe low next to a trap, and the trap must win. A watchdog overflow that coincides with all other sources must yield vector 0.

// File: rtl/exc_vec_arbiter.sv
module exc_vec_arbiter #(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               res_n,
  input  logic               wdt_ovf,
  input  logic               nmi_req,
  input  logic               trap_req,
  input  logic [1:0]         trap_code,
  input  logic               brk_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               irq_mask,
  input  logic               insn_boundary,
  output logic               exc_taken,
  output logic [VEC_W-1:0]   vec_num,
  output logic [ADDR_W-1:0]  vec_addr
);

  localparam int RESET_VEC = 0;
  localparam int NMI_VEC   = 7;
  localparam int TRAP_BASE = 8;
  localparam int IRQ_BASE  = TRAP_BASE + 4;
  localparam int BRK_VEC   = IRQ_BASE + NUM_IRQ;

  logic             res_done;
  logic             win;
  logic [VEC_W-1:0] win_vec;

  wire irq_open = insn_boundary && !irq_mask;

  // Lowest priority is assigned first; later, higher-priority sources override it.
  always_comb begin
    win     = 1'b0;
    win_vec = '0;
    if (insn_boundary && brk_req) begin
      win     = 1'b1;
      win_vec = VEC_W'(BRK_VEC);
    end
    if (irq_open) begin
      for (int k = NUM_IRQ - 1; k >= 0; k--) begin
        if (irq_req[k]) begin
          win     = 1'b1;
          win_vec = VEC_W'(IRQ_BASE + k);
        end
      end
    end
    if (trap_req) begin
      win     = 1'b1;
      win_vec = VEC_W'(TRAP_BASE) + VEC_W'(trap_code);
    end
    if (insn_boundary && nmi_req) begin
      win     = 1'b1;
      win_vec = VEC_W'(NMI_VEC);
    end
    if (!res_done || wdt_ovf) begin
      win     = 1'b1;
      win_vec = VEC_W'(RESET_VEC);
    end
  end

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      res_done  <= 1'b0;
      exc_taken <= 1'b0;
      vec_num   <= '0;
      vec_addr  <= '0;
    end else begin
      res_done  <= 1'b1;
      exc_taken <= win;
      if (win) begin
        vec_num  <= win_vec;
        vec_addr <= ADDR_W'(win_vec) << 1;
      end
    end
  end

  AST_WDT_IS_RESET: assert property (@(posedge clk) disable iff (!res_n)
    wdt_ovf |=> exc_taken && vec_num == '0); // R3

  AST_TRAP_ANY_CYCLE: assert property (@(posedge clk) disable iff (!res_n)
    (trap_req && !wdt_ovf && res_done && !(insn_boundary && nmi_req))
      |=> exc_taken && vec_num == VEC_W'(TRAP_BASE) + VEC_W'($past(trap_code))); // R5

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!res_n)
    (irq_mask && res_done && !wdt_ovf && !nmi_req && !trap_req && !brk_req) |=> !exc_taken); // R7

  AST_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!res_n)
    (!insn_boundary && res_done && !wdt_ovf && !trap_req) |=> !exc_taken); // R10

  AST_HOLD_VECTOR: assert property (@(posedge clk) disable iff (!res_n)
    !exc_taken |-> $stable(vec_num) && $stable(vec_addr)); // R11

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!res_n)
    exc_taken |-> (vec_num == '0 || vec_num >= VEC_W'(NMI_VEC))); // R12

  AST_ADDR_TRACKS: assert property (@(posedge clk) disable iff (!res_n)
    vec_addr == ADDR_W'(vec_num) * ADDR_W'(2)); // R12

endmodule

// File: tb/test_exc_vec_arbiter.sv
module test_exc_vec_arbiter;
  localparam int NUM_IRQ = 8;

  logic               clk = 1'b0;
  logic               res_n = 1'b0;
  logic               wdt_ovf = 1'b0, nmi_req = 1'b0, trap_req = 1'b0, brk_req = 1'b0;
  logic [1:0]         trap_code = 2'd0;
  logic [NUM_IRQ-1:0] irq_req = '0;
  logic               irq_mask = 1'b0, insn_boundary = 1'b0;
  logic               exc_taken;
  logic [7:0]         vec_num;
  logic [15:0]        vec_addr;

  int checks = 0, errors = 0;
  logic [7:0] q_vec[$];
  string      q_tag[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  exc_vec_arbiter #(.NUM_IRQ(NUM_IRQ), .VEC_W(8), .ADDR_W(16)) i_exc_vec_arbiter (
    .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .nmi_req(nmi_req),
    .trap_req(trap_req), .trap_code(trap_code), .brk_req(brk_req),
    .irq_req(irq_req), .irq_mask(irq_mask), .insn_boundary(insn_boundary),
    .exc_taken(exc_taken), .vec_num(vec_num), .vec_addr(vec_addr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops an expectation for every pulse it sees.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (res_n && exc_taken) begin
        if (q_vec.size() == 0) begin
          check(1'b0, "unexpected pulse R7/R10", int'(vec_num), -1);
        end else begin
          automatic logic [7:0] ev = q_vec.pop_front();
          automatic string      et = q_tag.pop_front();
          check(vec_num == ev, et, int'(vec_num), int'(ev));
          check(vec_addr == {7'd0, ev, 1'b0}, {et, " addr R12"}, int'(vec_addr), int'(ev) * 2);
        end
      end
    end
  end

  task automatic clear_inputs();
    wdt_ovf = 0; nmi_req = 0; trap_req = 0; trap_code = 0;
    brk_req = 0; irq_req = '0; irq_mask = 0; insn_boundary = 0;
  endtask

  // Driver: applies one cycle of stimulus and records the expected vector, if any.
  task automatic step(input bit wdt, input bit nmi, input bit trp, input logic [1:0] code,
                      input bit brk, input logic [NUM_IRQ-1:0] irq, input bit msk,
                      input bit bnd, input bit exp_valid, input int exp_vec, input string tag);
    @(negedge clk);
    wdt_ovf = wdt; nmi_req = nmi; trap_req = trp; trap_code = code;
    brk_req = brk; irq_req = irq; irq_mask = msk; insn_boundary = bnd;
    if (exp_valid) begin
      q_vec.push_back(8'(exp_vec));
      q_tag.push_back(tag);
    end
    @(negedge clk);
    clear_inputs();
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs idle during reset even with requests present
    repeat (3) @(negedge clk);
    irq_req = 8'hFF; nmi_req = 1; insn_boundary = 1; trap_req = 1;
    @(negedge clk);
    check(exc_taken == 0 && vec_num == 0 && vec_addr == 0, "R1 reset state",
          int'(vec_num) + int'(exc_taken), 0);
    clear_inputs();
    @(negedge clk);
    // R2: release produces the reset vector once
    res_n = 1;
    q_vec.push_back(8'd0); q_tag.push_back("R2 release");
    repeat (4) @(negedge clk);

    // R5: traps without a boundary
    for (int n = 0; n < 4; n++)
      step(0, 0, 1, 2'(n), 0, '0, 1, 0, 1, 8 + n, "R5 trap");
    // R4: non-maskable ignores the mask
    step(0, 1, 0, 0, 0, '0, 1, 1, 1, 7, "R4 nmi masked");
    // R6: maskable lines, lowest bit wins
    step(0, 0, 0, 0, 0, 8'h01, 0, 1, 1, 12, "R6 irq0");
    step(0, 0, 0, 0, 0, 8'hA0, 0, 1, 1, 17, "R6 irq5 of 5,7");
    step(0, 0, 0, 0, 0, 8'h80, 0, 1, 1, 19, "R6 irq7");
    // R7: mask blocks, vector holds (R11)
    step(0, 0, 0, 0, 0, 8'hFF, 1, 1, 0, 0, "R7");
    check(vec_num == 8'd19 && vec_addr == 16'h0026, "R7/R11 hold", int'(vec_num), 19);
    // R8: address break ignores the mask
    step(0, 0, 0, 0, 1, '0, 1, 1, 1, 20, "R8 brk");
    // R10: boundary-gated sources wait
    step(0, 1, 0, 0, 1, 8'h0F, 0, 0, 0, 0, "R10");
    check(vec_num == 8'd20 && exc_taken == 0, "R10 no pulse, R11 hold", int'(vec_num), 20);
    // R9: same-cycle contests
    step(0, 1, 1, 2'd3, 1, 8'hFF, 0, 1, 1, 7, "R9 nmi over trap");
    step(0, 0, 1, 2'd2, 1, 8'hFF, 0, 1, 1, 10, "R9 trap over irq");
    step(0, 0, 0, 0, 1, 8'h40, 0, 1, 1, 18, "R9 irq over brk");
    step(0, 1, 1, 2'd1, 0, '0, 0, 0, 1, 9, "R9 trap when nmi off boundary");
    // R3: watchdog overrides everything
    step(1, 1, 1, 2'd0, 1, 8'hFF, 0, 1, 1, 0, "R3 wdt");
    step(1, 0, 0, 0, 0, '0, 1, 0, 1, 0, "R3 wdt no boundary");
    // R11: single-cycle pulse
    @(negedge clk);
    check(exc_taken == 0, "R11 pulse width", int'(exc_taken), 0);
    // R1/R2 again in mid-run
    step(0, 0, 1, 2'd3, 0, '0, 0, 0, 1, 11, "R5 trap3");
    @(negedge clk);
    res_n = 0;
    @(negedge clk);
    check(exc_taken == 0 && vec_num == 0 && vec_addr == 0, "R1 re-reset", int'(vec_num), 0);
    res_n = 1;
    q_vec.push_back(8'd0); q_tag.push_back("R2 second release");
    repeat (4) @(negedge clk);
    check(q_vec.size() == 0, "all expected pulses seen R2", q_vec.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule